// File: doc/BRIEF.md
# Real-Mode Segmented Address Generator

This block turns a 16-bit segment and a 16-bit offset into a physical byte address, as early real-mode processors did. The segment is shifted up by four bit positions and added to the offset. Because of this, many segment:offset pairs name the same byte. The sum can be up to 21 bits wide. A gate input controls the top address line. When the gate is closed, bit 20 is dropped, the address space folds back at 1 MB, and a wrap flag reports that a carry was lost. When the gate is open, the 65,520 bytes starting at 1 MB (0x100000 to 0x10FFEF) can be reached.

Each result is also sorted into one region of the classic PC memory layout: the 640 KB low area, the 384 KB upper area used by firmware, video and I/O, and the high area above 1 MB. A request strobe starts a translation. The address, region and wrap flag appear registered on the next cycle, together with a one-cycle valid pulse, and they hold until the next request.

Top module: `seg_addr_gen`

## Requirements
- R1: With the gate input high, `phys_o` equals segment × 16 + offset as an unsigned 21-bit value.
- R2: With the gate input low, `phys_o[20]` is 0 and `phys_o[19:0]` equals the low 20 bits of segment × 16 + offset.
- R3: `wrap_o` is 1 exactly when the gate is low and segment × 16 + offset is at least 0x100000; otherwise it is 0.
- R4: `region_o` is 2'b00 (low area) when `phys_o` is below 0xA0000.
- R5: `region_o` is 2'b01 (upper area) when `phys_o` is in 0xA0000 to 0xFFFFF inclusive.
- R6: `region_o` is 2'b10 (high area) when `phys_o` is 0x100000 or above; the largest value reached is 0x10FFEF (segment 0xFFFF, offset 0xFFFF).
- R7: `valid_o` is high for exactly the one cycle after each cycle in which `req_i` is high, and is low otherwise.
- R8: In cycles without a request, `phys_o`, `region_o` and `wrap_o` keep their last values, whatever the other inputs do.
- R9: Different segment:offset pairs whose sums are equal produce the same `phys_o` and `region_o`.
- R10: While `rst_n` is low, `valid_o`, `phys_o` and `wrap_o` are 0 and `region_o` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Translation request strobe |
| seg_i | input | 16 | Segment value |
| off_i | input | 16 | Offset value |
| a20_en_i | input | 1 | Opens address line 20 when high |
| valid_o | output | 1 | Result pulse, one cycle after a request |
| phys_o | output | 21 | Physical byte address |
| region_o | output | 2 | 00 low area, 01 upper area, 10 high area |
| wrap_o | output | 1 | Carry into bit 20 was discarded |

## Verification
The assertions assume that `seg_i`, `off_i` and `a20_en_i` are stable and known in every cycle where `req_i` is high. Apart from that, they relate each result only to the inputs of the request cycle just before it. The bench changes all inputs on the falling edge, far from the sampling edge. It also changes segment, offset and gate freely while no request is pending, which drives the hold behaviour without leaving those assumptions. No input pattern can produce a sum above 0x10FFEF, so the high-area checks can rely on that ceiling.

// File: rtl/seg_pkg.sv
package seg_pkg;
    typedef enum logic [1:0] {
        REG_LOW   = 2'b00,
        REG_UPPER = 2'b01,
        REG_HIGH  = 2'b10
    } region_e;

    localparam int unsigned DEF_SEG_W = 16;
    localparam int unsigned DEF_OFF_W = 16;
    localparam int unsigned DEF_SHIFT = 4;
endpackage

// File: rtl/seg_addr_sum.sv
module seg_addr_sum #(
    parameter int unsigned SEG_W = 16,
    parameter int unsigned OFF_W = 16,
    parameter int unsigned SHIFT = 4,
    parameter int unsigned PA_W  = 21
) (
    input  logic [SEG_W-1:0] seg_i,
    input  logic [OFF_W-1:0] off_i,
    output logic [PA_W-1:0]  sum_o
);
    logic [PA_W-1:0] base;
    logic [PA_W-1:0] disp;

    always_comb begin
        base  = PA_W'(seg_i) << SHIFT;
        disp  = PA_W'(off_i);
        sum_o = base + disp;
    end
endmodule

// File: rtl/seg_a20_gate.sv
module seg_a20_gate #(
    parameter int unsigned PA_W = 21
) (
    input  logic [PA_W-1:0] sum_i,
    input  logic            open_i,
    output logic [PA_W-1:0] phys_o,
    output logic            lost_o
);
    localparam int unsigned TOP = PA_W - 1;

    for (genvar b = 0; b < PA_W; b++) begin : g_bit
        if (b == TOP) begin : g_top
            assign phys_o[b] = sum_i[b] & open_i;
        end else begin : g_low
            assign phys_o[b] = sum_i[b];
        end
    end

    assign lost_o = sum_i[TOP] & ~open_i;
endmodule

// File: rtl/seg_region_dec.sv
module seg_region_dec
    import seg_pkg::*;
#(
    parameter int unsigned PA_W      = 21,
    parameter int unsigned LOW_LIMIT = 32'h000A_0000
) (
    input  logic [PA_W-1:0] phys_i,
    output region_e         region_o
);
    localparam logic [PA_W-1:0] LOW_TOP  = PA_W'(LOW_LIMIT);
    localparam logic [PA_W-1:0] HIGH_BAS = PA_W'(1) << (PA_W - 1);

    always_comb begin
        if (phys_i >= HIGH_BAS) begin
            region_o = REG_HIGH;
        end else if (phys_i >= LOW_TOP) begin
            region_o = REG_UPPER;
        end else begin
            region_o = REG_LOW;
        end
    end
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
    import seg_pkg::*;
#(
    parameter int unsigned SEG_W     = DEF_SEG_W,
    parameter int unsigned OFF_W     = DEF_OFF_W,
    parameter int unsigned SHIFT     = DEF_SHIFT,
    parameter int unsigned LOW_LIMIT = 32'h000A_0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic [SEG_W-1:0] seg_i,
    input  logic [OFF_W-1:0] off_i,
    input  logic             a20_en_i,
    output logic             valid_o,
    output logic [SEG_W+SHIFT:0] phys_o,
    output logic [1:0]       region_o,
    output logic             wrap_o
);
    localparam int unsigned PA_W = SEG_W + SHIFT + 1;

    typedef struct packed {
        logic            valid;
        logic [PA_W-1:0] phys;
        region_e         region;
        logic            wrap;
    } res_t;

    logic [PA_W-1:0] sum_w;
    logic [PA_W-1:0] gated_w;
    logic            lost_w;
    region_e         region_w;

    res_t st_d;
    res_t st_q;

    seg_addr_sum #(
        .SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT), .PA_W(PA_W)
    ) sum_i (
        .seg_i(seg_i), .off_i(off_i), .sum_o(sum_w)
    );

    seg_a20_gate #(.PA_W(PA_W)) gate_i (
        .sum_i(sum_w), .open_i(a20_en_i), .phys_o(gated_w), .lost_o(lost_w)
    );

    seg_region_dec #(.PA_W(PA_W), .LOW_LIMIT(LOW_LIMIT)) dec_i (
        .phys_i(gated_w), .region_o(region_w)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = req_i;
        if (req_i) begin
            st_d.phys   = gated_w;
            st_d.region = region_w;
            st_d.wrap   = lost_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{valid: 1'b0, phys: '0, region: REG_LOW, wrap: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o  = st_q.valid;
    assign phys_o   = st_q.phys;
    assign region_o = st_q.region;
    assign wrap_o   = st_q.wrap;

    // R7: result pulse follows each request and only a request
    a_r7_valid_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> valid_o);
    a_r7_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> !valid_o);
    // R8: idle cycles leave the result untouched
    a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> ($stable(phys_o) && $stable(region_o) && $stable(wrap_o)));
    // R2: closed gate never lets bit 20 through
    a_r2_gate_clears_top: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !a20_en_i) |=> !phys_o[PA_W-1]);
    // R3: open gate never reports a lost carry
    a_r3_no_wrap_when_open: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && a20_en_i) |=> !wrap_o);
    // R6: high region only with bit 20 set
    a_r6_high_needs_top_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && region_o == REG_HIGH) |-> phys_o[PA_W-1]);
    // R4: low region stays under the limit
    a_r4_low_below_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && region_o == REG_LOW) |-> (phys_o < PA_W'(LOW_LIMIT)));
    // R3: a wrap always comes with a cleared top bit
    a_r3_wrap_top_clear: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |-> !phys_o[PA_W-1]);
endmodule

// File: tb/seg_addr_gen_tb.sv
module seg_addr_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [15:0] seg = '0;
    logic [15:0] off = '0;
    logic        a20 = 1'b0;
    logic        valid;
    logic [20:0] phys;
    logic [1:0]  region;
    logic        wrap;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    seg_addr_gen dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req), .seg_i(seg), .off_i(off),
        .a20_en_i(a20), .valid_o(valid), .phys_o(phys), .region_o(region),
        .wrap_o(wrap)
    );

    // {seg, off, gate, expected phys, expected region, expected wrap}
    localparam int NV = 15;
    localparam logic [56:0] VEC [NV] = '{
        {16'h0000, 16'h0000, 1'b1, 21'h000000, 2'b00, 1'b0},
        {16'h1234, 16'h0005, 1'b1, 21'h012345, 2'b00, 1'b0},
        {16'h1000, 16'h2345, 1'b0, 21'h012345, 2'b00, 1'b0},
        {16'h9000, 16'hFFFF, 1'b1, 21'h09FFFF, 2'b00, 1'b0},
        {16'hA000, 16'h0000, 1'b1, 21'h0A0000, 2'b01, 1'b0},
        {16'h9FFF, 16'h0010, 1'b1, 21'h0A0000, 2'b01, 1'b0},
        {16'hF000, 16'hFFFF, 1'b1, 21'h0FFFFF, 2'b01, 1'b0},
        {16'hFFFF, 16'h0010, 1'b1, 21'h100000, 2'b10, 1'b0},
        {16'hFFFF, 16'h0010, 1'b0, 21'h000000, 2'b00, 1'b1},
        {16'hFFFF, 16'hFFFF, 1'b1, 21'h10FFEF, 2'b10, 1'b0},
        {16'hFFFF, 16'hFFFF, 1'b0, 21'h00FFEF, 2'b00, 1'b1},
        {16'hB800, 16'h0000, 1'b0, 21'h0B8000, 2'b01, 1'b0},
        {16'hF800, 16'h8000, 1'b1, 21'h100000, 2'b10, 1'b0},
        {16'hFFFF, 16'h000F, 1'b0, 21'h0FFFFF, 2'b01, 1'b0},
        {16'hE000, 16'hFFFF, 1'b0, 21'h0EFFFF, 2'b01, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R10: reset state
        repeat (3) @(negedge clk);
        chk("R10 valid", 32'(valid), 0);
        chk("R10 phys", 32'(phys), 0);
        chk("R10 region", 32'(region), 0);
        chk("R10 wrap", 32'(wrap), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R7 idle valid", 32'(valid), 0);

        // vector walk: R1 R2 R3 R4 R5 R6 R9
        for (int i = 0; i < NV; i++) begin
            seg = VEC[i][56:41];
            off = VEC[i][40:25];
            a20 = VEC[i][24];
            req = 1'b1;
            @(negedge clk);
            req = 1'b0;
            chk($sformatf("R7 valid v%0d", i), 32'(valid), 1);
            chk($sformatf("R1/R2 phys v%0d", i), 32'(phys), 32'(VEC[i][23:3]));
            chk($sformatf("R4/R5/R6 region v%0d", i), 32'(region), 32'(VEC[i][2:1]));
            chk($sformatf("R3 wrap v%0d", i), 32'(wrap), 32'(VEC[i][0]));
            @(negedge clk);
            chk($sformatf("R7 pulse end v%0d", i), 32'(valid), 0);
        end

        // R9: alias pair issued back to back
        seg = 16'h1234; off = 16'h0005; a20 = 1'b1; req = 1'b1;
        @(negedge clk);
        chk("R9 first phys", 32'(phys), 32'h12345);
        seg = 16'h1000; off = 16'h2345; a20 = 1'b1;
        @(negedge clk);
        req = 1'b0;
        chk("R9 alias phys", 32'(phys), 32'h12345);
        chk("R7 back-to-back valid", 32'(valid), 1);

        // R8: inputs change without request, result held
        seg = 16'hFFFF; off = 16'hFFFF; a20 = 1'b0;
        repeat (3) @(negedge clk);
        chk("R8 hold phys", 32'(phys), 32'h12345);
        chk("R8 hold region", 32'(region), 0);
        chk("R8 hold wrap", 32'(wrap), 0);
        chk("R8 hold valid", 32'(valid), 0);

        // R10: reset clears a standing result
        seg = 16'hFFFF; off = 16'h0010; a20 = 1'b1; req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        chk("R6 pre-reset region", 32'(region), 2);
        rst_n = 1'b0;
        #1;
        chk("R10 async phys", 32'(phys), 0);
        chk("R10 async region", 32'(region), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule